// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table stored in memory. A client hands over one translation request at a time, with the virtual address and two access attributes: whether the access is a write, and whether it comes from user mode. The walker reads the first-level entry, and then the second-level entry, through a simple word-read port with a request/response handshake. It returns the physical address or a fault code.

Pages are 4 KB. Each table holds 1024 entries of 4 bytes, so one table fills one page. The virtual address splits into a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit page offset (bits 11:0). The offset passes through translation unchanged. The root table's page address comes from the `tableBase` input. Every entry has the same layout: a page number in bits 31:12, user-accessible in bit 2, writable in bit 1 and present in bit 0. The walker checks presence and access rights at both levels. A missing entry and a rights violation give different fault codes.

Top module: `page_walker`

## Requirements
- R1: While reset is held and right after it, `reqReady` is 1, and `rspValid` and `memReqValid` are 0.
- R2: The first memory read goes to `{tableBase[31:12], vaddr[31:22], 2'b00}`.
- R3: When the first-level entry passes its checks, the second read goes to `{pte1[31:12], vaddr[21:12], 2'b00}`.
- R4: When both entries pass, the response carries `rspPaddr = {pte2[31:12], vaddr[11:0]}` with `rspFault = 0` (none), after exactly two memory reads.
- R5: A first-level entry with bit 0 clear ends the walk with `rspFault = 1` (not present) after a single memory read.
- R6: A second-level entry with bit 0 clear gives `rspFault = 1` after two reads.
- R7: A write (`reqWrite = 1`) through an entry whose bit 1 is clear, at either level, gives `rspFault = 2` (protection).
- R8: A user access (`reqUser = 1`) through an entry whose bit 2 is clear gives `rspFault = 2`. A walk stops at the first entry that fails. When an entry is both not present and lacks the rights, the code is 1.
- R9: Only one request is in flight. `reqReady` stays 0 from the cycle a request is accepted until the response handshake completes. `rspValid`, `rspPaddr` and `rspFault` hold steady until `rspReady` is seen.
- R10: A memory request that is not accepted keeps `memReqValid` high and `memReqAddr` unchanged until `memReqReady` is 1.
- R11: Every fault response carries `rspPaddr = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access comes from user mode |
| tableBase | input | 32 | Address of the root table; bits 31:12 are used |
| memReqValid | output | 1 | Word read request to memory |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Entry read from memory |
| rspValid | output | 1 | Translation result present |
| rspReady | input | 1 | Client takes the result |
| rspPaddr | output | 32 | Physical address, 0 on a fault |
| rspFault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
A wrong internal state shows up at the ports within one or two memory transactions. A corrupted level register, or a wrongly latched entry, sends the second read to the wrong address. That is visible at the next `memReqAddr` handshake, before any response arrives. A fault check that is lost or reordered changes the number of memory reads and the `rspFault` code of that same walk. A state machine that leaves a waiting state too early either drops `rspValid` before `rspReady` or raises `reqReady` while a walk is in flight, both within one cycle. The directed walks repeat the path with memory back-pressure, so address-holding errors show up on the stalled cycles.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE   = 2'd0,
    FAULT_ABSENT = 2'd1,
    FAULT_PROT   = 2'd2
  } faultCode_e;

  localparam int ENTRY_PRESENT_BIT = 0;
  localparam int ENTRY_WRITE_BIT   = 1;
  localparam int ENTRY_USER_BIT    = 2;

  typedef struct packed {
    logic captureReq;
    logic loadPtr;
    logic loadResult;
    logic loadFault;
    logic useLevel2;
  } walkStrobes_t;

endpackage

// File: rtl/page_walker_ctrl.sv
module page_walker_ctrl
  import page_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         memReqValid,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output logic         rspValid,
  input  logic         rspReady,
  input  faultCode_e   checkCode,
  output walkStrobes_t strobes
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } walkState_e;

  walkState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobes.captureReq = 1'b1;
        stateNext = ST_L1_REQ;
      end
      ST_L1_REQ: if (memReqReady) stateNext = ST_L1_WAIT;
      ST_L1_WAIT: if (memRspValid) begin
        if (checkCode != FAULT_NONE) begin
          strobes.loadFault = 1'b1;
          stateNext = ST_FAULT;
        end else begin
          strobes.loadPtr = 1'b1;
          stateNext = ST_L2_REQ;
        end
      end
      ST_L2_REQ: begin
        strobes.useLevel2 = 1'b1;
        if (memReqReady) stateNext = ST_L2_WAIT;
      end
      ST_L2_WAIT: if (memRspValid) begin
        if (checkCode != FAULT_NONE) begin
          strobes.loadFault = 1'b1;
          stateNext = ST_FAULT;
        end else begin
          strobes.loadResult = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_DONE, ST_FAULT: if (rspReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign rspValid    = (state == ST_DONE) || (state == ST_FAULT);

  // R9: response held until taken
  assert_rsp_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

  // R9: no new request accepted while a walk or response is pending
  assert_single_walk_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R10: memory request held while not accepted
  assert_memreq_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R9: idle again right after the response handshake
  assert_return_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady |=> reqReady && !rspValid);

endmodule

// File: rtl/page_walker_datapath.sv
module page_walker_datapath
  import page_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  walkStrobes_t     strobes,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic [VA_W-1:0]  tableBase,
  input  logic [VA_W-1:0]  memRspData,
  output logic [VA_W-1:0]  memReqAddr,
  output faultCode_e       checkCode,
  output logic [VA_W-1:0]  rspPaddr,
  output faultCode_e       rspFault
);

  localparam int PPN_W     = VA_W - OFF_W;
  localparam int ENTRY_SH  = OFF_W - IDX_W;
  localparam int L1_LO     = VA_W - IDX_W;
  localparam int L2_LO     = OFF_W;

  logic [VA_W-1:0]  vaddrReg;
  logic             writeReg;
  logic             userReg;
  logic [PPN_W-1:0] tablePpn;
  logic [VA_W-1:0]  paddrReg;
  faultCode_e       faultReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrReg <= '0;
      writeReg <= 1'b0;
      userReg  <= 1'b0;
      tablePpn <= '0;
      paddrReg <= '0;
      faultReg <= FAULT_NONE;
    end else begin
      if (strobes.captureReq) begin
        vaddrReg <= reqVaddr;
        writeReg <= reqWrite;
        userReg  <= reqUser;
        paddrReg <= '0;
        faultReg <= FAULT_NONE;
      end
      if (strobes.loadPtr)    tablePpn <= memRspData[VA_W-1:OFF_W];
      if (strobes.loadResult) paddrReg <= {memRspData[VA_W-1:OFF_W], vaddrReg[OFF_W-1:0]};
      if (strobes.loadFault) begin
        paddrReg <= '0;
        faultReg <= checkCode;
      end
    end
  end

  always_comb begin
    if (!memRspData[ENTRY_PRESENT_BIT])
      checkCode = FAULT_ABSENT;
    else if ((writeReg && !memRspData[ENTRY_WRITE_BIT]) ||
             (userReg  && !memRspData[ENTRY_USER_BIT]))
      checkCode = FAULT_PROT;
    else
      checkCode = FAULT_NONE;
  end

  assign memReqAddr = strobes.useLevel2
    ? {tablePpn, vaddrReg[L2_LO +: IDX_W], {ENTRY_SH{1'b0}}}
    : {tableBase[VA_W-1:OFF_W], vaddrReg[L1_LO +: IDX_W], {ENTRY_SH{1'b0}}};

  assign rspPaddr = paddrReg;
  assign rspFault = faultReg;

  // R11: a latched fault never comes with a nonzero address
  assert_fault_zero_addr_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadFault |=> rspPaddr == '0 && rspFault != FAULT_NONE);

endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic            reqWrite,
  input  logic            reqUser,
  input  logic [VA_W-1:0] tableBase,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic [VA_W-1:0] memReqAddr,
  input  logic            memRspValid,
  input  logic [VA_W-1:0] memRspData,
  output logic            rspValid,
  input  logic            rspReady,
  output logic [VA_W-1:0] rspPaddr,
  output logic [1:0]      rspFault
);

  walkStrobes_t strobes;
  faultCode_e   checkCode;
  faultCode_e   faultOut;

  page_walker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspValid(rspValid), .rspReady(rspReady),
    .checkCode(checkCode), .strobes(strobes)
  );

  page_walker_datapath #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .tableBase(tableBase), .memRspData(memRspData),
    .memReqAddr(memReqAddr), .checkCode(checkCode),
    .rspPaddr(rspPaddr), .rspFault(faultOut)
  );

  assign rspFault = faultOut;

  // R10: stalled memory request keeps its address
  assert_memaddr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  // R9: response content steady while waiting for the client
  assert_rsp_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspPaddr) && $stable(rspFault));

  // R11: fault responses carry a zero address
  assert_fault_paddr_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault != 2'd0 |-> rspPaddr == '0);

  // R2: entry reads are word aligned
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[1:0] == 2'b00);

endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic [31:0] tableBase = 32'h0010_0000;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspPaddr;
  logic [1:0]  rspFault;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int readCount = 0;
  bit stallMode = 1'b0;
  logic [31:0] logAddr [64];
  logic [31:0] memA [8];
  logic [31:0] memD [8];

  always #4 clk = ~clk;

  page_walker dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .tableBase(tableBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr), .rspFault(rspFault)
  );

  function automatic logic [31:0] lookup(input logic [31:0] a);
    lookup = 32'h0;
    for (int i = 0; i < 8; i++) if (memA[i] == a) lookup = memD[i];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memRspValid <= 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= lookup(memReqAddr);
      logAddr[readCount % 64] <= memReqAddr;
      readCount <= readCount + 1;
    end
    memReqReady <= stallMode ? ((cyc % 3) == 2) : 1'b1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runWalk(input logic [31:0] va, input bit wr, input bit usr,
                         input logic [1:0] expFault, input logic [31:0] expPaddr,
                         input int expReads, input logic [31:0] expA1,
                         input logic [31:0] expA2, input string tag);
    int startCnt;
    @(negedge clk);
    startCnt = readCount;
    reqVaddr = va; reqWrite = wr; reqUser = usr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R9 busy after accept"}, {31'b0, reqReady}, 32'd0);
    while (!rspValid) @(negedge clk);
    check({tag, " R9 busy at response"}, {31'b0, reqReady}, 32'd0);
    check({tag, " fault code"}, {30'b0, rspFault}, {30'b0, expFault});
    check(expFault != 2'd0 ? {tag, " R11 paddr"} : {tag, " R4 paddr"}, rspPaddr, expPaddr);
    check({tag, " read count"}, readCount - startCnt, expReads);
    check({tag, " R2 first read address"}, logAddr[startCnt % 64], expA1);
    if (expReads > 1)
      check({tag, " R3 second read address"}, logAddr[(startCnt + 1) % 64], expA2);
    @(negedge clk);
    check({tag, " R9 held valid"}, {31'b0, rspValid}, 32'd1);
    check({tag, " R9 held paddr"}, rspPaddr, expPaddr);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check({tag, " R9 idle after handshake"}, {30'b0, rspValid, reqReady}, 32'd1);
  endtask

  task automatic testReset();
    check("R1 reqReady", {31'b0, reqReady}, 32'd1);
    check("R1 rspValid", {31'b0, rspValid}, 32'd0);
    check("R1 memReqValid", {31'b0, memReqValid}, 32'd0);
  endtask

  task automatic testSuccess();
    runWalk(32'h0040_5ABC, 1'b1, 1'b1, 2'd0, 32'h1234_5ABC, 2,
            32'h0010_0004, 32'h0020_0014, "R4 user write success");
  endtask

  task automatic testKernelRead();
    runWalk(32'h0080_3123, 1'b0, 1'b0, 2'd0, 32'h0ABC_D123, 2,
            32'h0010_0008, 32'h0030_000C, "R4 kernel read");
  endtask

  task automatic testWriteProt();
    runWalk(32'h0080_3123, 1'b1, 1'b0, 2'd2, 32'h0, 2,
            32'h0010_0008, 32'h0030_000C, "R7 write to read-only");
  endtask

  task automatic testUserProt();
    runWalk(32'h0080_3123, 1'b0, 1'b1, 2'd2, 32'h0, 1,
            32'h0010_0008, 32'h0, "R8 user to supervisor at level 1");
  endtask

  task automatic testL1Absent();
    runWalk(32'h00C0_0000, 1'b0, 1'b0, 2'd1, 32'h0, 1,
            32'h0010_000C, 32'h0, "R5 level 1 not present");
  endtask

  task automatic testL2Absent();
    runWalk(32'h0040_6010, 1'b0, 1'b0, 2'd1, 32'h0, 2,
            32'h0010_0004, 32'h0020_0018, "R6 level 2 not present");
  endtask

  task automatic testPriority();
    runWalk(32'h0100_0000, 1'b1, 1'b1, 2'd1, 32'h0, 1,
            32'h0010_0010, 32'h0, "R8 absent beats protection");
  endtask

  task automatic testStall();
    stallMode = 1'b1;
    runWalk(32'h0040_5ABC, 1'b0, 1'b1, 2'd0, 32'h1234_5ABC, 2,
            32'h0010_0004, 32'h0020_0014, "R10 stalled memory");
    stallMode = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin memA[i] = 32'hFFFF_FFFF; memD[i] = 32'h0; end
    memA[0] = 32'h0010_0004; memD[0] = 32'h0020_0007;
    memA[1] = 32'h0020_0014; memD[1] = 32'h1234_5007;
    memA[2] = 32'h0010_0008; memD[2] = 32'h0030_0003;
    memA[3] = 32'h0030_000C; memD[3] = 32'h0ABC_D001;
    memA[4] = 32'h0010_0010; memD[4] = 32'h0040_0000;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSuccess();
    testKernelRead();
    testWriteProt();
    testUserProt();
    testL1Absent();
    testL2Absent();
    testPriority();
    testStall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule